// File: doc/BRIEF.md
# Instruction Fetch Interface Protocol Monitor

This block is a synthesizable protocol monitor that sits beside an instruction cache. It watches the core-facing side of the cache (branch requests with their targets, the returned fetch beat with its address, data and error indications, and the valid/ready handshake) and the memory-facing side (request, grant and response-valid). It records each broken rule in its own flag, which stays set until reset, and it drives an aggregate fail output that is the OR of all flags. It holds no cache state and produces no stimulus. It only observes.

On the core side, a fetch beat counts as pending in a cycle when valid is high, ready is low and no branch is requested. In the cycle after a pending cycle, the monitor checks that valid is still high and that the address, the error indications and the instruction bits are unchanged. Which data bits must hold depends on whether the low half of the beat holds a compressed instruction. The monitor also keeps a bit that says whether the fetch stream has a known architectural address. On the memory side it counts outstanding granted requests, and it flags a response that arrives when nothing is outstanding.

Top module: `ifetch_proto_mon`

## Requirements
- R1: If a beat is pending in one cycle and, in the next cycle, valid is low while no branch is requested, `viol_valid_drop` is set. A beat that was accepted (valid and ready) or cancelled by a branch raises no flag when valid then falls.
- R2: If a beat is pending in one cycle and valid is high in the next cycle with a different returned address, `viol_addr_chg` is set.
- R3: If a beat is pending in one cycle and valid is high in the next cycle, a change of the error flag sets `viol_err_chg`. When the earlier error flag was high, a change of the upper-half error flag also sets it.
- R4: If a beat is pending with its error flag low, and valid is high in the next cycle, a change of data bits [15:0] sets `viol_data_chg`. A change of bits [31:16] also sets it, but only when the earlier bits [1:0] were both one (an uncompressed instruction). When those bits were not 2'b11, the upper half may change freely.
- R5: When valid, the error flag and the upper-half error flag are all high while data bits [1:0] are not 2'b11, `viol_err_enc` is set.
- R6: `addr_known` is 0 after reset. It becomes 1 after any cycle with a branch request. It returns to 0 after a cycle with valid, ready and the error flag high and no branch. An accepted beat without error leaves it unchanged.
- R7: `out_cnt` rises by one for each cycle with request and grant, and falls by one for each cycle with response-valid. Both in the same cycle leave it unchanged. A response-valid while `out_cnt` is 0 sets `viol_rsp_idle` and leaves the count at 0.
- R8: A grant without a response while `out_cnt` is at its maximum value (all ones) sets `viol_cnt_ovf`, and the count stays at the maximum.
- R9: A branch request whose target address has bit 0 set sets `viol_br_align`.
- R10: Every violation flag stays set until reset. `fail` is high exactly when at least one flag is set.
- R11: While reset is asserted, and at the first clock edge after its release, no rule is evaluated. All flags, `fail`, `out_cnt` and `addr_known` read 0 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| cor_branch | input | 1 | Core requests a fetch redirect |
| cor_br_tgt | input | ADDR_W | Redirect target address |
| cor_valid | input | 1 | Cache presents a fetch beat |
| cor_ready | input | 1 | Core accepts the beat |
| cor_addr | input | ADDR_W | Address of the presented beat |
| cor_rdata | input | DATA_W | Instruction bits of the beat |
| cor_err | input | 1 | Beat carries a fetch error |
| cor_err_hi | input | 1 | Error lies in the upper half of the beat |
| mem_req | input | 1 | Cache requests memory |
| mem_gnt | input | 1 | Memory grants the request |
| mem_rvalid | input | 1 | Memory returns a response |
| viol_valid_drop | output | 1 | Sticky: valid fell while a beat was pending |
| viol_addr_chg | output | 1 | Sticky: address moved while pending |
| viol_err_chg | output | 1 | Sticky: error indications moved while pending |
| viol_data_chg | output | 1 | Sticky: held instruction bits moved while pending |
| viol_err_enc | output | 1 | Sticky: upper-half error on a compressed low half |
| viol_br_align | output | 1 | Sticky: odd branch target |
| viol_rsp_idle | output | 1 | Sticky: response with nothing outstanding |
| viol_cnt_ovf | output | 1 | Sticky: outstanding count would overflow |
| fail | output | 1 | OR of all violation flags |
| addr_known | output | 1 | Fetch stream has a known architectural address |
| out_cnt | output | CNT_W | Outstanding granted requests |

## Verification
The core rules are tried with two-beat sequences. In each one, a pending beat is followed by a beat that holds, drops valid, is cancelled by a branch, or changes one field at a time. The pairs keep every field fixed except one, so each flag can be seen to respond to its own field and to no other. Paired sequences with the low half compressed and uncompressed separate the compression-dependent hold on the upper half. Error and non-error beats separate the cases where data stability is waived. On the memory side, runs of grants and responses, including same-cycle pairs, an underflowing response and a fill to the counter limit, separate counting from the idle-response rule and from saturation.

// File: rtl/ifm_pkg.sv
package ifm_pkg;

  localparam int NUM_RULES = 8;

  localparam int RULE_VALID_DROP = 0;
  localparam int RULE_ADDR_CHG   = 1;
  localparam int RULE_ERR_CHG    = 2;
  localparam int RULE_DATA_CHG   = 3;
  localparam int RULE_ERR_ENC    = 4;
  localparam int RULE_BR_ALIGN   = 5;
  localparam int RULE_RSP_IDLE   = 6;
  localparam int RULE_CNT_OVF    = 7;

  // Low two bits both set marks a 32-bit (uncompressed) instruction.
  function automatic logic is_full_width(input logic [1:0] opc_lsb);
    return (opc_lsb == 2'b11);
  endfunction

endpackage

// File: rtl/ifm_core_rules.sv
module ifm_core_rules #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              branch,
  input  logic [ADDR_W-1:0] br_tgt,
  input  logic              valid,
  input  logic              ready,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] rdata,
  input  logic              err,
  input  logic              err_hi,
  output logic              hit_valid_drop,
  output logic              hit_addr_chg,
  output logic              hit_err_chg,
  output logic              hit_data_chg,
  output logic              hit_err_enc,
  output logic              hit_br_align,
  output logic              addr_known
);
  import ifm_pkg::*;

  localparam int HALF_W = DATA_W / 2;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(1);

  // Captured view of the previous cycle
  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              err_q, err_d;
  logic              errhi_q, errhi_d;
  logic              known_q, known_d;
  logic              cap_en;

  logic [HALF_W-1:0] lo_now, lo_prev, hi_now, hi_prev;
  logic              prev_full;
  logic              hold_chk;

  assign lo_now  = rdata[HALF_W-1:0];
  assign hi_now  = rdata[DATA_W-1:HALF_W];
  assign lo_prev = data_q[HALF_W-1:0];
  assign hi_prev = data_q[DATA_W-1:HALF_W];

  // Next state: capture on every presented beat
  always_comb begin
    cap_en  = valid;
    pend_d  = valid & ~ready & ~branch;
    addr_d  = addr;
    data_d  = rdata;
    err_d   = err;
    errhi_d = err_hi;

    known_d = known_q;
    if (branch) begin
      known_d = 1'b1;
    end else if (valid && ready && err) begin
      known_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      known_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      known_q <= known_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
      errhi_q <= 1'b0;
    end else if (cap_en) begin
      addr_q  <= addr_d;
      data_q  <= data_d;
      err_q   <= err_d;
      errhi_q <= errhi_d;
    end
  end

  // Rule evaluation against the captured pending beat
  always_comb begin
    prev_full = is_full_width(lo_prev[1:0]);
    hold_chk  = pend_q & valid;

    hit_valid_drop = pend_q & ~valid & ~branch;
    hit_addr_chg   = hold_chk & (addr != addr_q);
    hit_err_chg    = hold_chk & ((err != err_q) |
                                 (err_q & (err_hi != errhi_q)));
    hit_data_chg   = hold_chk & ~err_q &
                     ((lo_now != lo_prev) | (prev_full & (hi_now != hi_prev)));
    hit_err_enc    = valid & err & err_hi & ~is_full_width(lo_now[1:0]);
    hit_br_align   = branch & ((br_tgt & ALIGN_MASK) != '0);
  end

  assign addr_known = known_q;

endmodule

// File: rtl/ifm_bus_tracker.sv
module ifm_bus_tracker #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             gnt,
  input  logic             rvalid,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_rsp_idle,
  output logic             hit_ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             inc, dec;
  logic             at_zero, at_max;

  always_comb begin
    inc     = req & gnt;
    at_zero = (cnt_q == '0);
    at_max  = (cnt_q == CNT_MAX);
    dec     = rvalid & ~at_zero;

    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (inc && !rvalid && !at_max) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + CNT_ONE;
    end else if (dec && !inc) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CNT_ONE;
    end

    hit_rsp_idle = rvalid & at_zero;
    hit_ovf      = inc & ~rvalid & at_max;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/ifm_sticky_bank.sv
module ifm_sticky_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         armed,
  input  logic [N-1:0] hit,
  output logic [N-1:0] flags,
  output logic         any
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic set_en;
    assign set_en = armed & hit[i] & ~flag_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[i] <= 1'b0;
      end else if (set_en) begin
        flag_q[i] <= 1'b1;
      end
    end
  end

  assign flags = flag_q;
  assign any   = |flag_q;

endmodule

// File: rtl/ifetch_proto_mon.sv
module ifetch_proto_mon #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cor_branch,
  input  logic [ADDR_W-1:0] cor_br_tgt,
  input  logic              cor_valid,
  input  logic              cor_ready,
  input  logic [ADDR_W-1:0] cor_addr,
  input  logic [DATA_W-1:0] cor_rdata,
  input  logic              cor_err,
  input  logic              cor_err_hi,
  input  logic              mem_req,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  output logic              viol_valid_drop,
  output logic              viol_addr_chg,
  output logic              viol_err_chg,
  output logic              viol_data_chg,
  output logic              viol_err_enc,
  output logic              viol_br_align,
  output logic              viol_rsp_idle,
  output logic              viol_cnt_ovf,
  output logic              fail,
  output logic              addr_known,
  output logic [CNT_W-1:0]  out_cnt
);
  import ifm_pkg::*;

  logic                 armed_q, armed_d;
  logic [NUM_RULES-1:0] hit;
  logic [NUM_RULES-1:0] flags;

  // Rules start one edge after reset release
  assign armed_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  ifm_core_rules #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_core (
    .clk            (clk),
    .rst_n          (rst_n),
    .branch         (cor_branch),
    .br_tgt         (cor_br_tgt),
    .valid          (cor_valid),
    .ready          (cor_ready),
    .addr           (cor_addr),
    .rdata          (cor_rdata),
    .err            (cor_err),
    .err_hi         (cor_err_hi),
    .hit_valid_drop (hit[RULE_VALID_DROP]),
    .hit_addr_chg   (hit[RULE_ADDR_CHG]),
    .hit_err_chg    (hit[RULE_ERR_CHG]),
    .hit_data_chg   (hit[RULE_DATA_CHG]),
    .hit_err_enc    (hit[RULE_ERR_ENC]),
    .hit_br_align   (hit[RULE_BR_ALIGN]),
    .addr_known     (addr_known)
  );

  ifm_bus_tracker #(
    .CNT_W(CNT_W)
  ) u_bus (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (mem_req),
    .gnt          (mem_gnt),
    .rvalid       (mem_rvalid),
    .cnt          (out_cnt),
    .hit_rsp_idle (hit[RULE_RSP_IDLE]),
    .hit_ovf      (hit[RULE_CNT_OVF])
  );

  ifm_sticky_bank #(
    .N(NUM_RULES)
  ) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (armed_q),
    .hit   (hit),
    .flags (flags),
    .any   (fail)
  );

  assign viol_valid_drop = flags[RULE_VALID_DROP];
  assign viol_addr_chg   = flags[RULE_ADDR_CHG];
  assign viol_err_chg    = flags[RULE_ERR_CHG];
  assign viol_data_chg   = flags[RULE_DATA_CHG];
  assign viol_err_enc    = flags[RULE_ERR_ENC];
  assign viol_br_align   = flags[RULE_BR_ALIGN];
  assign viol_rsp_idle   = flags[RULE_RSP_IDLE];
  assign viol_cnt_ovf    = flags[RULE_CNT_OVF];

endmodule

// File: rtl/ifetch_proto_mon_chk.sv
module ifetch_proto_mon_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cor_branch,
  input logic [ADDR_W-1:0] cor_br_tgt,
  input logic              cor_valid,
  input logic              cor_ready,
  input logic [ADDR_W-1:0] cor_addr,
  input logic              cor_err,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic              mem_rvalid,
  input logic [7:0]        flags,
  input logic              fail,
  input logic              addr_known,
  input logic [CNT_W-1:0]  out_cnt
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic chk_armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_armed <= 1'b0;
    else        chk_armed <= 1'b1;
  end

  p_valid_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && cor_valid && !cor_ready && !cor_branch) ##1 (!cor_valid && !cor_branch)
    |=> flags[0]);

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && cor_valid && !cor_ready && !cor_branch) ##1
    (cor_valid && (cor_addr != $past(cor_addr))) |=> flags[1]);

  p_err_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && cor_valid && !cor_ready && !cor_branch) ##1
    (cor_valid && (cor_err != $past(cor_err))) |=> flags[2]);

  p_br_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && cor_branch && cor_br_tgt[0]) |=> flags[5]);

  p_known_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cor_branch |=> addr_known);

  p_known_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_valid && cor_ready && cor_err && !cor_branch) |=> !addr_known);

  p_cnt_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && !mem_rvalid && out_cnt != CMAX)
    |=> (out_cnt == $past(out_cnt) + CNT_W'(1)));

  p_cnt_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt && mem_rvalid) |=> $stable(out_cnt));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_cnt == CMAX && mem_req && mem_gnt && !mem_rvalid) |=> (out_cnt == CMAX));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags != 8'h00) |=> ((flags & $past(flags)) == $past(flags)));

  p_fail_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fail == (flags != 8'h00));

  p_quiet_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_armed |=> (flags == 8'h00));

endmodule

bind ifetch_proto_mon ifetch_proto_mon_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cor_branch (cor_branch),
  .cor_br_tgt (cor_br_tgt),
  .cor_valid  (cor_valid),
  .cor_ready  (cor_ready),
  .cor_addr   (cor_addr),
  .cor_err    (cor_err),
  .mem_req    (mem_req),
  .mem_gnt    (mem_gnt),
  .mem_rvalid (mem_rvalid),
  .flags      ({viol_cnt_ovf, viol_rsp_idle, viol_br_align, viol_err_enc,
                viol_data_chg, viol_err_chg, viol_addr_chg, viol_valid_drop}),
  .fail       (fail),
  .addr_known (addr_known),
  .out_cnt    (out_cnt)
);

// File: tb/ifetch_proto_mon_bench.sv
module ifetch_proto_mon_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;
  localparam int ENT_W  = 98;
  localparam int N_ENT  = 13;

  // Entry: {ctlA(v,r,b,e,h), dataA, addrA, ctlB, dataB, addrB, expected flags}
  // Flag bit order: 0 valid drop, 1 addr, 2 err, 3 data, 4 err enc,
  // 5 branch align, 6 idle response, 7 overflow.
  localparam logic [ENT_W-1:0] TBL [N_ENT] = '{
    {5'b10000, 32'h1234_5673, 8'h10, 5'b00000, 32'h0000_0000, 8'h00, 8'h01}, // R1 drop
    {5'b10000, 32'h1234_5673, 8'h10, 5'b11000, 32'h1234_5673, 8'h10, 8'h00}, // R1 held
    {5'b10000, 32'h1234_5673, 8'h10, 5'b10000, 32'h1234_5673, 8'h14, 8'h02}, // R2
    {5'b10000, 32'h1234_5673, 8'h10, 5'b10010, 32'h1234_5673, 8'h10, 8'h04}, // R3 err
    {5'b10000, 32'h1234_5673, 8'h10, 5'b10000, 32'h9999_5673, 8'h10, 8'h08}, // R4 upper full
    {5'b10000, 32'h1234_5670, 8'h10, 5'b10000, 32'h9999_5670, 8'h10, 8'h00}, // R4 upper compr
    {5'b10011, 32'h1234_0001, 8'h10, 5'b10011, 32'h1234_0001, 8'h10, 8'h10}, // R5
    {5'b10011, 32'h1234_0003, 8'h10, 5'b10010, 32'h1234_0003, 8'h10, 8'h04}, // R3 err_hi
    {5'b10010, 32'h1234_5673, 8'h10, 5'b10010, 32'hABCD_0000, 8'h10, 8'h00}, // R4 waived on err
    {5'b11000, 32'h1234_5673, 8'h10, 5'b00000, 32'h0000_0000, 8'h00, 8'h00}, // R1 accepted
    {5'b00100, 32'h0000_0000, 8'h11, 5'b00000, 32'h0000_0000, 8'h00, 8'h20}, // R9
    {5'b10000, 32'h1234_5673, 8'h10, 5'b00100, 32'h0000_0000, 8'h20, 8'h00}, // R1 cancel
    {5'b10000, 32'h1234_5673, 8'h10, 5'b10000, 32'h1234_5677, 8'h10, 8'h08}  // R4 lower
  };

  logic              clk;
  logic              rst_n;
  logic              cor_branch;
  logic [ADDR_W-1:0] cor_br_tgt;
  logic              cor_valid;
  logic              cor_ready;
  logic [ADDR_W-1:0] cor_addr;
  logic [DATA_W-1:0] cor_rdata;
  logic              cor_err;
  logic              cor_err_hi;
  logic              mem_req;
  logic              mem_gnt;
  logic              mem_rvalid;
  logic              viol_valid_drop, viol_addr_chg, viol_err_chg, viol_data_chg;
  logic              viol_err_enc, viol_br_align, viol_rsp_idle, viol_cnt_ovf;
  logic              fail;
  logic              addr_known;
  logic [CNT_W-1:0]  out_cnt;
  logic [7:0]        flags;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  assign flags = {viol_cnt_ovf, viol_rsp_idle, viol_br_align, viol_err_enc,
                  viol_data_chg, viol_err_chg, viol_addr_chg, viol_valid_drop};

  ifetch_proto_mon #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W)
  ) u_ifetch_proto_mon (
    .clk(clk), .rst_n(rst_n),
    .cor_branch(cor_branch), .cor_br_tgt(cor_br_tgt),
    .cor_valid(cor_valid), .cor_ready(cor_ready),
    .cor_addr(cor_addr), .cor_rdata(cor_rdata),
    .cor_err(cor_err), .cor_err_hi(cor_err_hi),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .viol_valid_drop(viol_valid_drop), .viol_addr_chg(viol_addr_chg),
    .viol_err_chg(viol_err_chg), .viol_data_chg(viol_data_chg),
    .viol_err_enc(viol_err_enc), .viol_br_align(viol_br_align),
    .viol_rsp_idle(viol_rsp_idle), .viol_cnt_ovf(viol_cnt_ovf),
    .fail(fail), .addr_known(addr_known), .out_cnt(out_cnt)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic drive_core(input logic [4:0] ctl, input logic [31:0] data,
                            input logic [7:0] a);
    {cor_valid, cor_ready, cor_branch, cor_err, cor_err_hi} = ctl;
    cor_rdata  = data;
    cor_addr   = {24'h0, a};
    cor_br_tgt = {24'h0, a};
  endtask

  task automatic idle_all();
    drive_core(5'b00000, 32'h0, 8'h00);
    mem_req = 1'b0; mem_gnt = 1'b0; mem_rvalid = 1'b0;
  endtask

  task automatic do_reset(input bit arm);
    idle_all();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    if (arm) begin
      step(); step();
    end
  endtask

  task automatic bus(input logic g, input logic r);
    mem_req = g; mem_gnt = g; mem_rvalid = r;
    step();
    mem_req = 1'b0; mem_gnt = 1'b0; mem_rvalid = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle_all();

    // Reset state (R11)
    do_reset(1'b1);
    check("R11 flags after reset", {24'h0, flags}, 32'h0);
    check("R11 fail after reset", {31'h0, fail}, 32'h0);
    check("R11 count after reset", {28'h0, out_cnt}, 32'h0);
    check("R6 addr_known after reset", {31'h0, addr_known}, 32'h0);

    // Table walk: two-beat core sequences (R1..R5, R9, R10)
    for (int k = 0; k < N_ENT; k++) begin
      logic [ENT_W-1:0] e;
      e = TBL[k];
      do_reset(1'b1);
      drive_core(e[97:93], e[92:61], e[60:53]);
      step();
      drive_core(e[52:48], e[47:16], e[15:8]);
      step();
      check($sformatf("R1-5/R9 table entry %0d flags", k), {24'h0, flags}, {24'h0, e[7:0]});
      check($sformatf("R10 table entry %0d fail", k), {31'h0, fail}, {31'h0, (e[7:0] != 8'h00)});
      drive_core(5'b00100, 32'h0, 8'h00);
      step();
      idle_all();
      step(); step();
      check($sformatf("R10 table entry %0d sticky", k), {24'h0, flags}, {24'h0, e[7:0]});
    end

    // R11: violation in the first cycle after release is ignored
    idle_all();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    drive_core(5'b00100, 32'h0, 8'h11);
    step();
    idle_all();
    step();
    check("R11 no flag right after release", {24'h0, flags}, 32'h0);

    // R6 address tracking
    do_reset(1'b1);
    drive_core(5'b00100, 32'h0, 8'h40);
    step();
    check("R6 set by branch", {31'h0, addr_known}, 32'h1);
    drive_core(5'b11000, 32'h1234_5673, 8'h40);
    step();
    check("R6 kept on clean accept", {31'h0, addr_known}, 32'h1);
    drive_core(5'b11010, 32'h1234_5673, 8'h44);
    step();
    check("R6 cleared on error accept", {31'h0, addr_known}, 32'h0);
    idle_all();
    step();

    // R7 outstanding count and idle response
    do_reset(1'b1);
    bus(1'b1, 1'b0); bus(1'b1, 1'b0); bus(1'b1, 1'b0);
    check("R7 count after three grants", {28'h0, out_cnt}, 32'h3);
    bus(1'b1, 1'b1);
    check("R7 grant and response together", {28'h0, out_cnt}, 32'h3);
    mem_req = 1'b1; mem_gnt = 1'b0; mem_rvalid = 1'b0;
    step();
    check("R7 request without grant", {28'h0, out_cnt}, 32'h3);
    bus(1'b0, 1'b1); bus(1'b0, 1'b1); bus(1'b0, 1'b1);
    check("R7 count drained", {28'h0, out_cnt}, 32'h0);
    check("R7 no idle flag while drained", {31'h0, viol_rsp_idle}, 32'h0);
    bus(1'b0, 1'b1);
    check("R7 idle response flagged", {31'h0, viol_rsp_idle}, 32'h1);
    check("R7 count stays zero", {28'h0, out_cnt}, 32'h0);

    // R8 saturation at the counter limit
    do_reset(1'b1);
    for (int i = 0; i < 15; i++) bus(1'b1, 1'b0);
    check("R8 count at limit", {28'h0, out_cnt}, 32'hF);
    check("R8 no flag at limit", {31'h0, viol_cnt_ovf}, 32'h0);
    bus(1'b1, 1'b0);
    check("R8 overflow flagged", {31'h0, viol_cnt_ovf}, 32'h1);
    check("R8 count saturated", {28'h0, out_cnt}, 32'hF);
    check("R10 fail follows overflow", {31'h0, fail}, 32'h1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule